// File: doc/BRIEF.md
# Interrupt Presenter Thread Context

This block holds the interrupt presentation state of one hardware thread. It keeps three rings of byte registers: a guest-OS ring, a hypervisor pool ring and a hypervisor physical ring. Each ring records which priorities are pending, the most favoured pending priority, the thread's current priority threshold and a notification status byte. A per-ring exception line is raised while that ring's status byte is non-zero.

An event router delivers priority-tagged notifications over a valid/ready stream. A notification is transferred on a clock edge where `notify_valid` and `notify_ready` are both high. The block lowers `notify_ready` in every cycle in which an MMIO access is presented, so register updates made by software never race with a notification. The router must hold the notification stable until it is accepted.

Software uses a single-beat MMIO port. Every access is taken in the cycle it is presented. A read answers one cycle later on `rsp_valid`/`rsp_data`, and writes produce no response. Some reads change state as a side effect. A read at 0x800 acknowledges the highest physical-ring interrupt. A read at 0x828 pulls the pool virtual-processor context.

Top module: `ipt_thread_ctx`

## Requirements
- R1: After reset every ring reads CPPR 0xFF, IPB 0x00, NSR 0x00 and PIPR 0xFF. All exception lines are low and the pool context word reads 0.
- R2: Ring bases are 0x010 (OS, ring 0), 0x020 (pool, ring 1) and 0x030 (physical, ring 2). The byte offsets within a ring are NSR 0x0, CPPR 0x1, IPB 0x2 and PIPR 0x7. Offsets 0x3 to 0x6 read as 0. A read returns its value in `rsp_data[7:0]`, zero-extended, with `rsp_valid` high in the cycle after the access.
- R3: An accepted notification sets IPB bit `notify_prio` of the ring selected by `notify_ring` (0 OS, 1 pool, 2 physical). A notification with ring code 3 is accepted and discarded.
- R4: PIPR reads as the index of the lowest set IPB bit, or 0xFF when IPB is zero.
- R5: NSR becomes the ring's code whenever PIPR is numerically lower than CPPR, and 0 otherwise. The codes are 0x80 for OS, 0x40 for pool and 0x80 for physical. `exc_o[r]` is high exactly while ring r's NSR is non-zero, from the edge that accepts the notification or write.
- R6: A write to a ring's CPPR offset loads `mmio_wdata[7:0]`. Only priorities numerically below CPPR raise the exception, so 0xFF admits all of them and lowering CPPR to the pending PIPR drops the line.
- R7: A read at 0x800 while physical NSR is non-zero returns bits 15:14 = NSR[7:6] (2 = physical), bits 13:8 = 0 and bits 7:0 = the PIPR. On the same edge it sets CPPR to that PIPR, clears that IPB bit and clears NSR, so `exc_o[2]` is low when `rsp_valid` rises.
- R8: A read at 0x800 while physical NSR is zero returns type 0 with the current CPPR and changes nothing.
- R9: The pool context word at 0x028 is a 32-bit read/write register. Bit 31 is its valid flag.
- R10: A read at 0x828 returns the pool context word and clears its bit 31, keeping bits 30:0.
- R11: Writes to NSR, IPB, PIPR or unmapped addresses have no effect, and unmapped reads return 0.
- R12: `notify_ready` is low in any cycle with `mmio_valid` high. A held notification is accepted on the first edge after the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmio_valid | input | 1 | MMIO access present this cycle |
| mmio_write | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | 12 | Byte address |
| mmio_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| notify_valid | input | 1 | Notification offered |
| notify_ready | output | 1 | Notification can be taken |
| notify_ring | input | 2 | Target ring code |
| notify_prio | input | 3 | Priority of the notification |
| exc_o | output | 3 | Per-ring exception lines |

## Verification
A wrong pending mask or threshold first appears on `exc_o` on the edge after the offending notification or CPPR write. It then appears in the acknowledge response, where the returned priority and type would disagree with the sequence of notifications sent. A stale status byte shows as an exception line that stays high after an acknowledge, or as a second acknowledge that returns a non-zero type. Pool context corruption appears on the next read of 0x028 or 0x828.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int NUM_RINGS = 3;
  localparam int RING_OS   = 0;
  localparam int RING_POOL = 1;
  localparam int RING_HV   = 2;

  localparam logic [3:0] OFF_NSR  = 4'h0;
  localparam logic [3:0] OFF_CPPR = 4'h1;
  localparam logic [3:0] OFF_IPB  = 4'h2;
  localparam logic [3:0] OFF_PIPR = 4'h7;

  localparam logic [11:0] ADDR_ACK     = 12'h800;
  localparam logic [11:0] ADDR_PULL    = 12'h828;
  localparam logic [11:0] ADDR_POOL_W2 = 12'h028;

  function automatic logic [7:0] nsr_code(int ring);
    return (ring == RING_POOL) ? 8'h40 : 8'h80;
  endfunction
endpackage

// File: rtl/ipt_prio_enc.sv
module ipt_prio_enc #(
  parameter int NUM_PRIO = 8
) (
  input  logic [NUM_PRIO-1:0] mask,
  output logic [7:0]          prio
);
  always_comb begin
    prio = 8'hFF;
    for (int i = NUM_PRIO - 1; i >= 0; i--) begin
      if (mask[i]) prio = 8'(i);
    end
  end
endmodule

// File: rtl/ipt_ring.sv
module ipt_ring #(
  parameter int         NUM_PRIO = 8,
  parameter logic [7:0] NSR_CODE = 8'h80,
  localparam int        PRIO_W   = $clog2(NUM_PRIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                notify_set,
  input  logic [PRIO_W-1:0]   notify_prio,
  input  logic                cppr_we,
  input  logic [7:0]          cppr_wdata,
  input  logic                ack,
  output logic [7:0]          cppr_q,
  output logic [NUM_PRIO-1:0] ipb_q,
  output logic [7:0]          nsr_q,
  output logic [7:0]          pipr
);
  logic [NUM_PRIO-1:0] ipb_set, ipb_clr, ipb_nxt;
  logic [7:0]          cppr_nxt, pipr_nxt;
  logic                ack_take;

  ipt_prio_enc #(.NUM_PRIO(NUM_PRIO)) u_enc_cur (.mask(ipb_q),   .prio(pipr));
  ipt_prio_enc #(.NUM_PRIO(NUM_PRIO)) u_enc_nxt (.mask(ipb_nxt), .prio(pipr_nxt));

  assign ack_take = ack && (nsr_q != 8'h00);
  assign ipb_set  = notify_set ? (NUM_PRIO'(1) << notify_prio) : '0;
  assign ipb_clr  = ack_take ? (NUM_PRIO'(1) << pipr[PRIO_W-1:0]) : '0;
  assign ipb_nxt  = (ipb_q & ~ipb_clr) | ipb_set;

  always_comb begin
    cppr_nxt = cppr_q;
    if (ack_take)     cppr_nxt = pipr;
    else if (cppr_we) cppr_nxt = cppr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= 8'hFF;
      ipb_q  <= '0;
      nsr_q  <= 8'h00;
    end else begin
      cppr_q <= cppr_nxt;
      ipb_q  <= ipb_nxt;
      if (ack_take)                 nsr_q <= 8'h00;
      else if (pipr_nxt < cppr_nxt) nsr_q <= NSR_CODE;
      else                          nsr_q <= 8'h00;
    end
  end

  assert_ack_cppr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (cppr_q == $past(pipr)));
  assert_nsr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nsr_q != 8'h00) |-> (pipr < cppr_q));
  assert_pipr_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipr == 8'hFF) |-> (ipb_q == '0));
  assert_notify_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    notify_set |=> ipb_q[$past(notify_prio)]);
endmodule

// File: rtl/ipt_thread_ctx.sv
module ipt_thread_ctx
  import ipt_pkg::*;
#(
  parameter int  NUM_PRIO = 8,
  parameter int  ADDR_W   = 12,
  parameter int  DATA_W   = 32,
  localparam int PRIO_W   = $clog2(NUM_PRIO)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mmio_valid,
  input  logic                 mmio_write,
  input  logic [ADDR_W-1:0]    mmio_addr,
  input  logic [DATA_W-1:0]    mmio_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data,
  input  logic                 notify_valid,
  output logic                 notify_ready,
  input  logic [1:0]           notify_ring,
  input  logic [PRIO_W-1:0]    notify_prio,
  output logic [NUM_RINGS-1:0] exc_o
);
  logic [7:0]          cppr [NUM_RINGS];
  logic [NUM_PRIO-1:0] ipb  [NUM_RINGS];
  logic [7:0]          nsr  [NUM_RINGS];
  logic [7:0]          pipr [NUM_RINGS];

  logic              rd, wr, in_ring, is_ack, is_pull, is_w2;
  logic [1:0]        ring_sel;
  logic [3:0]        offs;
  logic [DATA_W-1:0] rdata;
  logic [31:0]       pool_w2_q;

  assign rd       = mmio_valid && !mmio_write;
  assign wr       = mmio_valid &&  mmio_write;
  assign in_ring  = (mmio_addr[ADDR_W-1:6] == '0) && (mmio_addr[5:4] != 2'b00);
  assign ring_sel = mmio_addr[5:4] - 2'd1;
  assign offs     = mmio_addr[3:0];
  assign is_ack   = (mmio_addr == ADDR_W'(ADDR_ACK));
  assign is_pull  = (mmio_addr == ADDR_W'(ADDR_PULL));
  assign is_w2    = (mmio_addr == ADDR_W'(ADDR_POOL_W2));

  assign notify_ready = !mmio_valid;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    logic ack_r;
    if (r == RING_HV) begin : g_ack
      assign ack_r = rd && is_ack;
    end else begin : g_noack
      assign ack_r = 1'b0;
    end
    ipt_ring #(.NUM_PRIO(NUM_PRIO), .NSR_CODE(nsr_code(r))) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .notify_set  (notify_valid && notify_ready && (notify_ring == 2'(r))),
      .notify_prio (notify_prio),
      .cppr_we     (wr && in_ring && (ring_sel == 2'(r)) && (offs == OFF_CPPR)),
      .cppr_wdata  (mmio_wdata[7:0]),
      .ack         (ack_r),
      .cppr_q      (cppr[r]),
      .ipb_q       (ipb[r]),
      .nsr_q       (nsr[r]),
      .pipr        (pipr[r])
    );
    assign exc_o[r] = (nsr[r] != 8'h00);
  end

  always_comb begin
    rdata = '0;
    if (is_ack) begin
      rdata[15:14] = nsr[RING_HV][7:6];
      rdata[7:0]   = (nsr[RING_HV] != 8'h00) ? pipr[RING_HV] : cppr[RING_HV];
    end else if (is_pull || is_w2) begin
      rdata = DATA_W'(pool_w2_q);
    end else if (in_ring && ring_sel != 2'd3) begin
      case (offs)
        OFF_NSR:  rdata[7:0] = nsr[ring_sel];
        OFF_CPPR: rdata[7:0] = cppr[ring_sel];
        OFF_IPB:  rdata[7:0] = 8'(ipb[ring_sel]);
        OFF_PIPR: rdata[7:0] = pipr[ring_sel];
        default:  rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      pool_w2_q <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rdata;
      if (rd && is_pull)      pool_w2_q[31] <= 1'b0;
      else if (wr && is_w2)   pool_w2_q     <= mmio_wdata[31:0];
    end
  end

  assert_pull_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_pull) |=> !pool_w2_q[31]);
  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));
  assert_hold_under_mmio_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_valid |=> $stable(ipb[RING_HV]) || $past(rd && is_ack));
endmodule

// File: tb/tb_ipt_thread_ctx.sv
module tb_ipt_thread_ctx;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mmio_valid = 0, mmio_write = 0;
  logic [11:0] mmio_addr = '0;
  logic [31:0] mmio_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        notify_valid = 0, notify_ready;
  logic [1:0]  notify_ring = '0;
  logic [2:0]  notify_prio = '0;
  logic [2:0]  exc_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ipt_thread_ctx dut (
    .clk(clk), .rst_n(rst_n), .mmio_valid(mmio_valid), .mmio_write(mmio_write),
    .mmio_addr(mmio_addr), .mmio_wdata(mmio_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .notify_valid(notify_valid), .notify_ready(notify_ready),
    .notify_ring(notify_ring), .notify_prio(notify_prio), .exc_o(exc_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected response", rsp_data, 32'hDEAD);
      else chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
  end

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    mmio_valid = 1; mmio_write = 0; mmio_addr = a;
    @(negedge clk);
    mmio_valid = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    mmio_valid = 1; mmio_write = 1; mmio_addr = a; mmio_wdata = d;
    @(negedge clk);
    mmio_valid = 0; mmio_write = 0;
  endtask

  task automatic ntf(logic [1:0] ring, logic [2:0] prio);
    @(negedge clk);
    notify_valid = 1; notify_ring = ring; notify_prio = prio;
    @(negedge clk);
    notify_valid = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 exc after reset", 32'(exc_o), 0);
    for (int r = 1; r <= 3; r++) begin
      rd(12'(r * 16 + 0), 32'h00, "R1 NSR reset");
      rd(12'(r * 16 + 1), 32'hFF, "R1 CPPR reset");
      rd(12'(r * 16 + 2), 32'h00, "R1 IPB reset");
      rd(12'(r * 16 + 7), 32'hFF, "R1 PIPR reset");
    end
    rd(12'h028, 0, "R1 pool word reset");
    rd(12'h033, 0, "R2 reserved byte");
    rd(12'h100, 0, "R11 unmapped read");

    ntf(2, 5);
    chk("R5 exc HV after notify", 32'(exc_o), 32'b100);
    ntf(2, 2);
    rd(12'h032, 32'h24, "R3 HV IPB");
    rd(12'h037, 32'h02, "R4 HV PIPR");
    rd(12'h030, 32'h80, "R5 HV NSR");
    rd(12'h800, 32'h8002, "R7 ack");
    chk("R7 exc drops after ack", 32'(exc_o[2]), 0);
    rd(12'h031, 32'h02, "R7 CPPR after ack");
    rd(12'h032, 32'h20, "R7 IPB after ack");
    rd(12'h800, 32'h0002, "R8 empty ack");
    rd(12'h031, 32'h02, "R8 CPPR unchanged");

    wr(12'h031, 32'hFF);
    chk("R6 open CPPR raises exc", 32'(exc_o[2]), 1);
    rd(12'h800, 32'h8005, "R7 second ack");
    rd(12'h032, 32'h00, "R7 IPB empty");

    wr(12'h011, 32'h03);
    ntf(0, 4);
    chk("R6 masked prio no exc", 32'(exc_o[0]), 0);
    ntf(0, 1);
    chk("R6 favoured prio exc", 32'(exc_o[0]), 1);
    rd(12'h010, 32'h80, "R5 OS NSR");
    wr(12'h011, 32'h01);
    chk("R6 lowered CPPR drops exc", 32'(exc_o[0]), 0);

    ntf(1, 0);
    chk("R5 pool exc", 32'(exc_o[1]), 1);
    rd(12'h020, 32'h40, "R5 pool NSR");
    ntf(3, 7);
    rd(12'h012, 32'h12, "R3 OS IPB");
    rd(12'h022, 32'h01, "R3 pool IPB");
    rd(12'h032, 32'h00, "R3 ring 3 discarded");

    wr(12'h032, 32'hFF);
    wr(12'h030, 32'h80);
    wr(12'h037, 32'h00);
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h032, 32'h00, "R11 IPB write ignored");
    rd(12'h030, 32'h00, "R11 NSR write ignored");
    rd(12'h037, 32'hFF, "R11 PIPR write ignored");

    wr(12'h028, 32'h8000_1234);
    rd(12'h028, 32'h8000_1234, "R9 pool word");
    rd(12'h828, 32'h8000_1234, "R10 pull returns");
    rd(12'h028, 32'h0000_1234, "R10 valid cleared");

    // R12: notification held while an MMIO read is in flight
    exp_q.push_back(32'h00); tag_q.push_back("R12 read before accept");
    @(negedge clk);
    notify_valid = 1; notify_ring = 2; notify_prio = 6;
    mmio_valid = 1; mmio_write = 0; mmio_addr = 12'h032;
    #1 chk("R12 ready low", 32'(notify_ready), 0);
    @(negedge clk);
    mmio_valid = 0;
    #1 chk("R12 ready high", 32'(notify_ready), 1);
    @(negedge clk);
    notify_valid = 0;
    rd(12'h032, 32'h40, "R12 accepted after access");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule